// File: doc/BRIEF.md
# Clock-Select Control Register Bank

This block holds the control word that steers a small set of clock-source selectors and their gate enables. Software reaches it through a simple register interface with several write ports, one per bus master. Besides plain writes to the main word, it offers a bit-set alias and a bit-clear alias. Two masters can therefore flip separate bits of the same word in the same cycle without a read-modify-write race.

Select fields written by software are only pending. A selector with a commit bit passes its pending value to its live select output only when software writes a one to that bit in the commit register. A selector without a commit bit follows its field at once. Gate bits are active-high "clock off" and act as soon as they are written. A commit of an out-of-range select is refused and recorded in a sticky error flag. The live select outputs feed glitch-free switching cells, which sit outside this block.

Default selector layout (field bits / number of sources / gate bit / commit bit): selector 0 uses bits [1:0] / 3 / 7 / 0; selector 1 uses bits [10:8] / 5 / 15 / 1; selector 2 uses bits [17:16] / 4 / none / none.

Top module: `clksel_regbank`

## Requirements
- R1: In reset, and in the cycle after it, the main word reads 0x0000_8080: selects are zero and gate bits 7 and 15 are set. The live selects are zero, `gate_off` is 3'b011, `upd_strobe` is zero and the error flag is clear.
- R2: A write to address 0 replaces the main word. It reads back at addresses 0, 1 and 2 from the next cycle.
- R3: A write to address 1 ORs its one-bits into the main word and leaves the other bits unchanged.
- R4: A write to address 2 clears the main-word bits that are one in its data. If one bit is set and cleared in the same cycle, the clear wins.
- R5: In any cycle, a write to address 0 overrides every alias write. Among several writes to address 0, the lowest-numbered port wins.
- R6: `gate_off` for selectors 0 and 1 equals main-word bits 7 and 15, valid in the cycle after the write. Selector 2 has no gate and always reports 0 (running).
- R7: Writing a one to bit 0 or bit 1 at address 3 commits the pending field of selector 0 or 1 to `sel_active`. The matching `upd_strobe` bit is high for exactly the next cycle. Address 3 reads as zero.
- R8: The live select of selectors 0 and 1 does not change without a commit, even when their pending field changes.
- R9: Selector 2's live select takes its new field value on the same clock edge that writes the main word.
- R10: Status at address 4 has bit 0 = sticky error and bit 1+i = pending field of selector i not below that selector's source count.
- R11: A commit, or for selector 2 a write, of an out-of-range value leaves the live select unchanged. It sets the error flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NUM_PORTS | Write enable per port |
| wr_addr | input | 3*NUM_PORTS | Write address per port, port 0 in the low bits |
| wr_data | input | 32*NUM_PORTS | Write data per port, port 0 in the low bits |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| sel_active | output | 9 | Live select per selector, 3 bits each, selector 0 in the low bits |
| gate_off | output | 3 | One means the selector's clock is off |
| upd_strobe | output | 3 | One-cycle commit pulse per selector |

## Verification
The stimulus covers single-port direct writes, set-only writes, clear-only writes and commit writes. It also drives both ports at once: set against clear on the same bit, set against a direct write, and two direct writes. Each pattern separates the merge priorities from one another. Pending fields are changed without a commit to show that staged selectors hold their value. The direct-follow selector is changed in the same steps to show it does not wait for a commit. Out-of-range values are committed in both kinds of lane to tell a refused commit from an accepted one. Every clock is compared against a behavioural model.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int DW   = 32;
    localparam int AW   = 3;
    localparam int SW   = 3;
    localparam int NSEL = 3;

    typedef enum logic [AW-1:0] {
        A_MAIN = 3'd0,
        A_SET  = 3'd1,
        A_CLR  = 3'd2,
        A_UPD  = 3'd3,
        A_STAT = 3'd4
    } addr_e;

    typedef struct packed {
        int shift;
        int width;
        int nsrc;
        int gate;   // -1: no gate bit
        int upd;    // -1: no commit bit
    } sel_cfg_t;

    function automatic sel_cfg_t sel_cfg(input int i);
        sel_cfg_t c;
        case (i)
            0:       c = '{shift: 0,  width: 2, nsrc: 3, gate: 7,  upd: 0};
            1:       c = '{shift: 8,  width: 3, nsrc: 5, gate: 15, upd: 1};
            default: c = '{shift: 16, width: 2, nsrc: 4, gate: -1, upd: -1};
        endcase
        return c;
    endfunction

    function automatic logic [DW-1:0] reset_word();
        logic [DW-1:0] w;
        w = '0;
        for (int i = 0; i < NSEL; i++) begin
            if (sel_cfg(i).gate >= 0) w[sel_cfg(i).gate] = 1'b1;
        end
        return w;
    endfunction
endpackage

// File: rtl/clksel_wr_merge.sv
module clksel_wr_merge
    import clksel_pkg::*;
#(
    parameter int NP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NP-1:0]     wr_en,
    input  logic [NP*AW-1:0]  wr_addr,
    input  logic [NP*DW-1:0]  wr_data,
    input  logic [DW-1:0]     main_q,
    output logic [DW-1:0]     main_d,
    output logic [DW-1:0]     upd_word
);
    logic [DW-1:0] set_acc, clr_acc, dir_val;
    logic          dir_hit;

    always_comb begin
        set_acc  = '0;
        clr_acc  = '0;
        upd_word = '0;
        dir_val  = '0;
        dir_hit  = 1'b0;
        // highest port first so the lowest port's direct write lands last
        for (int p = NP - 1; p >= 0; p--) begin
            if (wr_en[p]) begin
                case (wr_addr[p*AW +: AW])
                    A_MAIN: begin dir_hit = 1'b1; dir_val = wr_data[p*DW +: DW]; end
                    A_SET:  set_acc  = set_acc  | wr_data[p*DW +: DW];
                    A_CLR:  clr_acc  = clr_acc  | wr_data[p*DW +: DW];
                    A_UPD:  upd_word = upd_word | wr_data[p*DW +: DW];
                    default: ;
                endcase
            end
        end
        main_d = dir_hit ? dir_val : ((main_q | set_acc) & ~clr_acc);
    end

    // R3: without direct or clear writes, no bit of the word is lost
    a_r3_set_keeps_bits: assert property (@(posedge clk) disable iff (rst)
        (!dir_hit && clr_acc == '0) |-> ((main_d & main_q) == main_q));
    // R4: a bit named by a clear write is zero unless a direct write wins
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (!dir_hit) |-> ((main_d & clr_acc) == '0));
endmodule

// File: rtl/clksel_lane.sv
module clksel_lane
    import clksel_pkg::*;
#(
    parameter int NSRC   = 2,
    parameter bit STAGED = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] cand,
    input  logic          take,
    input  logic [SW-1:0] pending,
    output logic [SW-1:0] active,
    output logic          strobe,
    output logic          reject,
    output logic          pend_bad
);
    localparam logic [SW:0] LIM = (SW+1)'(NSRC);

    logic cand_ok;
    assign cand_ok  = {1'b0, cand} < LIM;
    assign reject   = take && !cand_ok;
    assign pend_bad = !({1'b0, pending} < LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (take && cand_ok) begin
                active <= cand;
                strobe <= STAGED;
            end
        end
    end

    // R11: the live select never leaves the legal range
    a_r11_active_in_range: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, active} < LIM));

    if (STAGED) begin : g_staged_chk
        // R7: a strobe only follows a commit request
        a_r7_strobe_after_commit: assert property (@(posedge clk) disable iff (rst)
            strobe |-> $past(take));
        // R8: without a commit the live select holds
        a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
            !$past(take) |-> $stable(active));
    end
endmodule

// File: rtl/clksel_regbank.sv
module clksel_regbank
    import clksel_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_PORTS-1:0]    wr_en,
    input  logic [NUM_PORTS*AW-1:0] wr_addr,
    input  logic [NUM_PORTS*DW-1:0] wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    output logic [NSEL*SW-1:0]      sel_active,
    output logic [NSEL-1:0]         gate_off,
    output logic [NSEL-1:0]         upd_strobe
);
    localparam logic [DW-1:0] RST_WORD = reset_word();

    logic [DW-1:0]   main_q, main_d, upd_word;
    logic [NSEL-1:0] rej, pend_bad;
    logic            err_q;

    clksel_wr_merge #(.NP(NUM_PORTS)) u_merge (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_q(main_q), .main_d(main_d), .upd_word(upd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= RST_WORD;
            err_q  <= 1'b0;
        end else begin
            main_q <= main_d;
            err_q  <= err_q | (|rej);
        end
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        localparam sel_cfg_t C  = sel_cfg(g);
        localparam int       SH = C.shift;
        localparam int       WD = C.width;
        localparam int       GB = C.gate;
        localparam int       UB = C.upd;

        logic [SW-1:0] fld_q, fld_d, cand;
        logic          take;

        assign fld_q = SW'(main_q[SH +: WD]);
        assign fld_d = SW'(main_d[SH +: WD]);

        if (UB >= 0) begin : g_staged
            assign cand = fld_q;
            assign take = upd_word[UB];
        end else begin : g_direct
            assign cand = fld_d;
            assign take = 1'b1;
        end

        if (GB >= 0) begin : g_gate
            assign gate_off[g] = main_q[GB];
        end else begin : g_nogate
            assign gate_off[g] = 1'b0;
        end

        clksel_lane #(.NSRC(C.nsrc), .STAGED(UB >= 0)) u_lane (
            .clk(clk), .rst(rst),
            .cand(cand), .take(take), .pending(fld_q),
            .active(sel_active[g*SW +: SW]),
            .strobe(upd_strobe[g]),
            .reject(rej[g]),
            .pend_bad(pend_bad[g])
        );
    end

    logic unused_upd;
    assign unused_upd = ^upd_word;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_MAIN, A_SET, A_CLR: rd_data = main_q;
            A_STAT: begin
                rd_data[0]      = err_q;
                rd_data[NSEL:1] = pend_bad;
            end
            default: rd_data = '0;
        endcase
    end

    // R11: the error flag is sticky until reset
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(err_q) |-> err_q);
    // R2: the main word only changes through a bus write
    a_r2_word_needs_write: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) == '0) |-> $stable(main_q));
endmodule

// File: tb/test_clksel_regbank.sv
`timescale 1ns/1ps
module test_clksel_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wr_en = '0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [8:0]  sel_active;
    logic [2:0]  gate_off, upd_strobe;

    always #2.5 clk = ~clk;

    clksel_regbank #(.NUM_PORTS(2)) i_clksel_regbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sel_active(sel_active),
        .gate_off(gate_off), .upd_strobe(upd_strobe)
    );

    int checks = 0;
    int errors = 0;

    // behavioural model
    int sh[3]   = '{0, 8, 16};
    int wd[3]   = '{2, 3, 2};
    int ns[3]   = '{3, 5, 4};
    int gb[3]   = '{7, 15, -1};
    int ub[3]   = '{0, 1, -1};
    logic [31:0] m;
    int act[3];
    bit es[3];
    bit err;

    function automatic int fld(logic [31:0] w, int i);
        return int'((w >> sh[i]) & ((32'd1 << wd[i]) - 1));
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        logic [8:0]  ea;
        logic [2:0]  eg, es_v;
        logic [31:0] er;
        for (int i = 0; i < 3; i++) begin
            ea[i*3 +: 3] = 3'(act[i]);
            eg[i]        = (gb[i] >= 0) ? m[gb[i]] : 1'b0;
            es_v[i]      = es[i];
        end
        case (rd_addr)
            3'd0, 3'd1, 3'd2: er = m;
            3'd4: begin
                er = 32'd0;
                er[0] = err;
                for (int i = 0; i < 3; i++) er[1+i] = (fld(m, i) >= ns[i]);
            end
            default: er = 32'd0;
        endcase
        chk(tag, "rd_data", rd_data, er);
        chk(tag, "sel_active", 32'(sel_active), 32'(ea));
        chk(tag, "gate_off", 32'(gate_off), 32'(eg));
        chk(tag, "upd_strobe", 32'(upd_strobe), 32'(es_v));
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1;
        wr_en = '0;
        rd_addr = 3'd0;
        repeat (2) @(posedge clk);
        m = 32'h0000_8080;
        err = 1'b0;
        for (int i = 0; i < 3; i++) begin act[i] = 0; es[i] = 1'b0; end
        @(negedge clk);
        compare(tag);           // R1: during reset
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        compare(tag);           // R1: first cycle after reset
    endtask

    task automatic step(string tag, bit e0, logic [2:0] a0, logic [31:0] d0,
                        bit e1, logic [2:0] a1, logic [31:0] d1, logic [2:0] ra);
        logic [31:0] s, c, u, dv, nm;
        logic [2:0]  aa[2];
        logic [31:0] dd[2];
        bit          en[2];
        bit          hit;
        wr_en   = {e1, e0};
        wr_addr = {a1, a0};
        wr_data = {d1, d0};
        rd_addr = ra;
        en[0] = e0; en[1] = e1; aa[0] = a0; aa[1] = a1; dd[0] = d0; dd[1] = d1;
        s = 0; c = 0; u = 0; dv = 0; hit = 1'b0;
        for (int p = 1; p >= 0; p--) begin
            if (en[p]) begin
                case (aa[p])
                    3'd0: begin hit = 1'b1; dv = dd[p]; end
                    3'd1: s = s | dd[p];
                    3'd2: c = c | dd[p];
                    3'd3: u = u | dd[p];
                    default: ;
                endcase
            end
        end
        nm = hit ? dv : ((m | s) & ~c);
        for (int i = 0; i < 3; i++) begin
            int f;
            es[i] = 1'b0;
            if (ub[i] >= 0) begin
                if (u[ub[i]]) begin
                    f = fld(m, i);
                    if (f < ns[i]) begin act[i] = f; es[i] = 1'b1; end
                    else err = 1'b1;
                end
            end else begin
                f = fld(nm, i);
                if (f < ns[i]) act[i] = f;
                else err = 1'b1;
            end
        end
        m = nm;
        @(posedge clk);
        @(negedge clk);
        wr_en = '0;
        compare(tag);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset("R1");
        step("R2", 1, 3'd0, 32'h0000_0201, 0, 3'd0, 0, 3'd0);        // R6 gates on
        step("R7", 1, 3'd3, 32'h1, 0, 3'd0, 0, 3'd3);                 // commit sel0, reads 0
        step("R7", 0, 3'd0, 0, 0, 3'd0, 0, 3'd4);                     // strobe drops
        step("R3", 0, 3'd0, 0, 1, 3'd1, 32'h0001_0000, 3'd1);         // R9 sel2 follows
        step("R8", 1, 3'd2, 32'h1, 0, 3'd0, 0, 3'd0);                 // pending 0, live stays 1
        step("R4", 1, 3'd2, 32'h200, 1, 3'd1, 32'h200, 3'd0);         // clear beats set
        step("R5", 1, 3'd1, 32'hFF, 1, 3'd0, 32'h0000_8003, 3'd4);    // direct beats set; R10
        step("R11", 1, 3'd3, 32'h3, 0, 3'd0, 0, 3'd4);                // sel0 refused
        step("R5", 1, 3'd0, 32'h0000_0402, 1, 3'd0, 32'h1, 3'd0);     // port 0 wins
        step("R7", 0, 3'd0, 0, 1, 3'd3, 32'h3, 3'd3);                 // both commit
        step("R10", 1, 3'd0, 32'h0000_0600, 0, 3'd0, 0, 3'd4);        // sel1 pending 6
        step("R11", 1, 3'd3, 32'h2, 0, 3'd0, 0, 3'd4);                // refused, err stays
        step("R6", 1, 3'd1, 32'h8080, 0, 3'd0, 0, 3'd0);              // both gates off
        step("R6", 0, 3'd0, 0, 1, 3'd2, 32'h80, 3'd2);                // gate0 on
        step("R9", 1, 3'd1, 32'h0003_0000, 0, 3'd0, 0, 3'd0);         // sel2 -> 3
        step("R11", 0, 3'd0, 0, 0, 3'd0, 0, 3'd4);                    // err still set
        do_reset("R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule